// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Controller

This block watches a bank of 32 general-purpose input lines, finds events on them and merges the pending events into one interrupt request. It keeps the last sample of every line and compares it with the current one each clock, so it only detects anything while its clock runs. After reset every line reports any change. Software can switch a line to a selectable detector that fires on a rising edge, a falling edge, a high level or a low level.

Each detected event sets a sticky per-line status bit. A per-line enable mask gates these bits into the single interrupt output. Reading the status register returns every pending bit and clears them all. A line in level mode sets its bit again on every cycle that the level persists, so its interrupt comes back after a read until the source goes away.

All configuration uses write-one-to-set and write-one-to-clear register pairs, each with a readable view. The registers are reached through a single-cycle select/write port. Read data is combinational in the access cycle.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset, the enable mask, the alternate-mode mask, the kind view and the polarity view read 0. The status register reads 0 and irq_out is low.
- R2: A write to address 0 sets the enable bits at the 1 positions of the write data. A write to address 1 clears them. Bits written as 0 stay as they were, and the enable mask reads back at address 2.
- R3: A line whose alternate-mode bit is 0 records an event on any change between two consecutive clock samples, whether rising or falling.
- R4: A write to address 3 sets alternate-mode bits and a write to address 4 clears them. The alternate-mode mask reads at address 5.
- R5: A write to address 7 selects level detection and a write to address 6 selects edge detection. The kind view at address 8 reads 1 for level and 0 for edge.
- R6: A write to address 10 selects rising/high and a write to address 9 selects falling/low. The polarity view at address 11 reads 1 for rising/high and 0 for falling/low.
- R7: In alternate edge mode, a line records only transitions in the selected direction.
- R8: In alternate level mode, the status bit is set on every clock where the line holds the selected level, so it is present again after a status read.
- R9: irq_out is high exactly when some line has both its status bit and its enable bit set. Status bits are recorded regardless of the enable mask.
- R10: A read of address 12 returns the pending status and clears it in the same access. An event detected in the cycle of that read stays pending for the next read.
- R11: Lines that are held high through reset produce no event when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sampling and all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read for the access |
| bus_addr | input | 4 | Register address (0..12) |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| line_in | input | 32 | Synchronized input lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench targets a status read that coincides with a new event. A design that cleared after merging would lose that event, and one that cleared nothing would report the old bits twice. Level lines are read back-to-back while the level holds. A design that treated level as a one-shot would return zero on the second read. Rising and falling selections are driven with both transitions, which catches swapped polarity or an edge detector that ignores direction. Lines are held high through reset, which exposes a sample register that is not primed and so reports a false edge. Enable writes that carry zeros in some bit positions show whether a design overwrites the mask instead of setting or clearing only the written bits.

// File: rtl/gpio_evt_pkg.sv
// Shared register addresses for the GPIO event controller.
// Assumes a 4-bit word address on the register port.
package gpio_evt_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_EN_SET   = 4'd0,
        A_EN_CLR   = 4'd1,
        A_EN_VIEW  = 4'd2,
        A_XM_SET   = 4'd3,
        A_XM_CLR   = 4'd4,
        A_XM_VIEW  = 4'd5,
        A_SEL_EDGE = 4'd6,
        A_SEL_LVL  = 4'd7,
        A_KIND     = 4'd8,
        A_SEL_FALL = 4'd9,
        A_SEL_RISE = 4'd10,
        A_POL      = 4'd11,
        A_STATUS   = 4'd12
    } gpio_reg_e;
endpackage

// File: rtl/gpio_w1_reg.sv
// Per-line configuration bits driven by a write-1-to-set / write-1-to-clear pair.
// Assumes the set and clear strobes never arrive in the same cycle (different addresses).
module gpio_w1_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] set_bits;
    logic [WIDTH-1:0] clr_bits;

    // Qualify write data by the strobes.
    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    // Merge set and clear into the held bits; zeros leave bits alone.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/gpio_evt_detect.sv
// Per-line event detector: any-change by default, or selectable edge/level with polarity.
// Assumes line_in is already synchronized to clk. Edge detection is suppressed until the
// first post-reset sample has been taken, so reset gives no false edge.
module gpio_evt_detect #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] xmode,
    input  logic [LINES-1:0] is_level,
    input  logic [LINES-1:0] pol_hi,
    output logic [LINES-1:0] evt
);
    logic [LINES-1:0] prev_q;
    logic             primed_q;

    // Keep the previous sample and note that it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= line_in;
            primed_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic changed;
        logic at_pol;

        // Decode this line's event from its mode bits.
        always_comb begin
            changed = primed_q & (line_in[g] ^ prev_q[g]);
            at_pol  = pol_hi[g] ? line_in[g] : ~line_in[g];
            if (!xmode[g])        evt[g] = changed;
            else if (is_level[g]) evt[g] = at_pol;
            else                  evt[g] = changed & at_pol;
        end
    end
endmodule

// File: rtl/gpio_evt_status.sv
// Sticky event status with clear-on-read. Events in the clearing cycle survive.
module gpio_evt_status #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] evt,
    input  logic             rd_clr,
    output logic [LINES-1:0] stat
);
    // Accumulate events; a read wipes old bits before this cycle's events merge in.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat <= '0;
        else if (rd_clr) stat <= evt;
        else             stat <= stat | evt;
    end
endmodule

// File: rtl/gpio_evt_irq.sv
// GPIO event controller top: register decode, four set/clear config banks,
// detector, status and the combined interrupt. One access per cycle on the
// register port; read data is combinational.
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  line_in,
    output logic              irq_out
);
    localparam int NBANK = 4;

    logic [LINES-1:0] mask_q, xm_q, lvl_q, pol_q, stat_q, evt;
    logic [NBANK-1:0] set_we, clr_we;
    logic [LINES-1:0] bank_q [NBANK];
    logic             wr_en, rd_en, rd_stat;

    // Qualify the access type.
    always_comb begin
        wr_en   = bus_sel &  bus_wr;
        rd_en   = bus_sel & ~bus_wr;
        rd_stat = rd_en & (bus_addr == A_STATUS);
    end

    // Per-bank strobes; the level and rising selects are the "set" side.
    always_comb begin
        set_we[0] = wr_en & (bus_addr == A_EN_SET);
        clr_we[0] = wr_en & (bus_addr == A_EN_CLR);
        set_we[1] = wr_en & (bus_addr == A_XM_SET);
        clr_we[1] = wr_en & (bus_addr == A_XM_CLR);
        set_we[2] = wr_en & (bus_addr == A_SEL_LVL);
        clr_we[2] = wr_en & (bus_addr == A_SEL_EDGE);
        set_we[3] = wr_en & (bus_addr == A_SEL_RISE);
        clr_we[3] = wr_en & (bus_addr == A_SEL_FALL);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_w1_reg #(.WIDTH(LINES)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we[b]),
            .clr_we (clr_we[b]),
            .wdata  (bus_wdata),
            .q      (bank_q[b])
        );
    end

    // Name the banks.
    always_comb begin
        mask_q = bank_q[0];
        xm_q   = bank_q[1];
        lvl_q  = bank_q[2];
        pol_q  = bank_q[3];
    end

    gpio_evt_detect #(.LINES(LINES)) det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .xmode    (xm_q),
        .is_level (lvl_q),
        .pol_hi   (pol_q),
        .evt      (evt)
    );

    gpio_evt_status #(.LINES(LINES)) stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .rd_clr (rd_stat),
        .stat   (stat_q)
    );

    // Read multiplexer; write-only and unused addresses read 0.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                A_EN_VIEW: bus_rdata = mask_q;
                A_XM_VIEW: bus_rdata = xm_q;
                A_KIND:    bus_rdata = lvl_q;
                A_POL:     bus_rdata = pol_q;
                A_STATUS:  bus_rdata = stat_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Combined interrupt: any pending line that is enabled.
    always_comb irq_out = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_evt_irq_chk.sv
// Property checker for gpio_evt_irq, attached with bind below.
module gpio_evt_irq_chk
    import gpio_evt_pkg::*;
#(
    parameter int LINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]  bus_wdata,
    input logic              irq_out,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  stat_q,
    input logic [LINES-1:0]  evt,
    input logic              line0,
    input logic              xm0,
    input logic              lvl0,
    input logic              pol0
);
    logic rd_stat;
    always_comb rd_stat = bus_sel && !bus_wr && (bus_addr == A_STATUS);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_q == '0 && mask_q == '0 && !irq_out));

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_EN_SET)
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_EN_CLR)
        |=> ((mask_q & $past(bus_wdata)) == '0));

    assert_level_reassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xm0 && lvl0 && (pol0 == line0)) |=> stat_q[0]);

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (mask_q != '0 && stat_q != '0));

    assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> ((stat_q & ~$past(evt)) == '0));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.LINES(LINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .evt       (evt),
    .line0     (line_in[0]),
    .xm0       (xm_q[0]),
    .lvl0      (lvl_q[0]),
    .pol0      (pol_q[0])
);

// File: tb/gpio_evt_irq_tb_top.sv
// Self-checking bench: vector table for the default mode, then directed tests.
module gpio_evt_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_in = '0;
    logic        irq_out;

    int checks = 0;
    int fails = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    gpio_evt_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_in(line_in), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] ln;
        logic        crd;
        logic [31:0] erd;
        logic        cirq;
        logic        eirq;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0,1'b1,4'd12,32'h0,  32'h00,1'b1,32'h00,1'b1,1'b0,8'd1},  // R1 quiet start
        '{1'b1,1'b0,4'd0, 32'hF0, 32'h01,1'b0,32'h00,1'b1,1'b0,8'd2},  // R2 enable set, bit0 rises
        '{1'b0,1'b1,4'd2, 32'h0,  32'h01,1'b1,32'hF0,1'b1,1'b0,8'd2},  // R2 mask view
        '{1'b0,1'b1,4'd12,32'h0,  32'h01,1'b1,32'h01,1'b0,1'b0,8'd3},  // R3 rise seen, unmasked
        '{1'b1,1'b0,4'd1, 32'h20, 32'h11,1'b0,32'h00,1'b1,1'b0,8'd2},  // R2 clear bit5 only
        '{1'b0,1'b1,4'd2, 32'h0,  32'h11,1'b1,32'hD0,1'b1,1'b1,8'd9},  // R9 bit4 pending+enabled
        '{1'b0,1'b1,4'd12,32'h0,  32'h10,1'b1,32'h10,1'b1,1'b1,8'd10}, // R10 read, bit0 falls now
        '{1'b0,1'b1,4'd12,32'h0,  32'h10,1'b1,32'h01,1'b1,1'b0,8'd10}, // R10 event survived read
        '{1'b0,1'b1,4'd12,32'h0,  32'h10,1'b1,32'h00,1'b1,1'b0,8'd3}   // R3 stable line, no event
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle starting at a falling edge; samples read data and irq before the rising edge.
    task automatic cyc(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic irq_s);
        bus_sel = w | r; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        rd = bus_rdata; irq_s = irq_out;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] rd; logic ir;
        cyc(1'b1, 1'b0, a, d, rd, ir);
    endtask

    task automatic rdchk(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] rd; logic ir;
        cyc(1'b0, 1'b1, a, '0, rd, ir);
        chk(req, rd, exp);
    endtask

    task automatic idle();
        logic [31:0] rd; logic ir;
        cyc(1'b0, 1'b0, 4'd0, '0, rd, ir);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 5000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=5000", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic        ir;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        for (int i = 0; i < 9; i++) begin
            line_in = VECS[i].ln;
            cyc(VECS[i].wr, VECS[i].rd, VECS[i].a, VECS[i].d, rd, ir);
            if (VECS[i].crd) chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rd, VECS[i].erd);
            if (VECS[i].cirq) chk($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, ir}, {31'b0, VECS[i].eirq});
        end

        // R6 R4 R5: high-level detection on bit 8, configured without stray events.
        wr(4'd10, 32'h100);
        wr(4'd3, 32'h100);
        wr(4'd7, 32'h100);
        rdchk(4'd5, 32'h100, "R4 alt-mode view");
        rdchk(4'd8, 32'h100, "R5 kind view level");
        rdchk(4'd11, 32'h100, "R6 polarity view high");
        rdchk(4'd12, 32'h0, "R8 no event while low");
        line_in = 32'h110;
        idle();
        rdchk(4'd12, 32'h100, "R8 high level first read");
        rdchk(4'd12, 32'h100, "R8 high level re-asserted");
        line_in = 32'h10;
        idle();
        rdchk(4'd12, 32'h100, "R8 last level cycle");
        rdchk(4'd12, 32'h0, "R8 level gone");
        // R8 low level on bit 8.
        wr(4'd9, 32'h100);
        rdchk(4'd11, 32'h0, "R6 polarity view low");
        rdchk(4'd12, 32'h100, "R8 low level read");
        rdchk(4'd12, 32'h100, "R8 low level re-asserted");
        wr(4'd4, 32'h100);
        rdchk(4'd5, 32'h0, "R4 alt-mode cleared");
        rdchk(4'd12, 32'h100, "R8 pending from last level cycle");
        rdchk(4'd12, 32'h0, "R3 default mode, stable line");

        // R7 rising-only then falling-only on bit 9.
        wr(4'd3, 32'h200);
        wr(4'd10, 32'h200);
        line_in = 32'h210; idle();
        rdchk(4'd12, 32'h200, "R7 rising edge seen");
        line_in = 32'h10; idle();
        rdchk(4'd12, 32'h0, "R7 falling ignored in rising mode");
        wr(4'd9, 32'h200);
        line_in = 32'h210; idle();
        rdchk(4'd12, 32'h0, "R7 rising ignored in falling mode");
        line_in = 32'h10; idle();
        rdchk(4'd12, 32'h200, "R7 falling edge seen");
        wr(4'd7, 32'h200);
        wr(4'd6, 32'h200);
        rdchk(4'd8, 32'h100, "R5 edge select clears only bit9");

        // R11 R1: lines high through reset give no event; config is back to zero.
        line_in = 32'hFFFF_FFFF;
        rst_n = 1'b0;
        repeat (3) idle();
        rst_n = 1'b1;
        idle(); idle();
        cyc(1'b0, 1'b1, 4'd12, '0, rd, ir);
        chk("R11 no event after reset", rd, 32'h0);
        chk("R1 irq low after reset", {31'b0, ir}, 32'h0);
        rdchk(4'd2, 32'h0, "R1 mask zero");
        rdchk(4'd5, 32'h0, "R1 alt-mode zero");
        rdchk(4'd8, 32'h0, "R1 kind zero");
        rdchk(4'd11, 32'h0, "R1 polarity zero");
        wr(4'd0, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b0, 4'd0, '0, rd, ir);
        chk("R9 enabled but nothing pending", {31'b0, ir}, 32'h0);

        finish_run();
    end
endmodule